// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a bus-mastering network controller. Host software builds a ring of descriptors in a shared memory. Each descriptor is four 32-bit words: a status word at offset 0, a control word at offset 4, a buffer address at offset 8, and a next-address word at offset 12. The next-address word is never read. The block keeps a pointer into this ring. It polls the current descriptor until the host marks it as device-owned, then reads its control and buffer words and waits for a frame. A frame is a byte stream with start and end markers. Its bytes are packed into 32-bit words and written into the descriptor's buffer. When the frame ends, a completion status word is written back into the descriptor, which returns it to the host.

The host hands a descriptor back by setting its ownership bit again. A frame that begins while the current descriptor is still owned by the host is discarded and counted. The ring is entered at a programmed base address each time reception is switched on. A wrap flag in the last descriptor's control word sends the engine back to the base.

Memory access uses a single port. A read returns its data on the cycle after the read strobe. A write takes effect at the clock edge that ends the cycle in which its strobe is high.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, `mem_rd` and `mem_wr` are low and `missed_cnt` is 0. While `cfg_rx_en` is low and no frame is in progress, the memory port stays idle.
- R2: When reception is switched on from the off state, the ring pointer is loaded from `cfg_base`, with the low four bits of `cfg_base` forced to zero.
- R3: The engine reads the status word at pointer+0 until bit 31 (ownership) is 1. It then reads the control word at pointer+4 and the buffer address at pointer+8. Bits 13:0 of the control word give the buffer size in bytes, and bit 25 is the wrap flag.
- R4: Frame byte k goes to the buffer word at buffer+4*(k/4), in byte lane k%4 (bits 8*(k%4)+7 down to 8*(k%4)). A final partial word is written with its unused lanes set to zero.
- R5: After the last data word, the status word at pointer+0 is written as follows: bit 31 = 0, bits 29:16 = total bytes received (including the 4 CRC bytes carried in the stream), bit 15 = error summary, bit 8 = 1 (last descriptor), all other bits 0.
- R6: Bytes beyond the buffer size are not written and set the error-summary bit. A frame exactly as long as the buffer leaves the bit clear.
- R7: After the status write, the pointer moves to pointer+16, or to the masked base if the wrap flag was set.
- R8: A start-of-frame that arrives while enabled but not armed with a device-owned descriptor drops the whole frame. Nothing is written, the pointer does not move, and `missed_cnt` increases by one, saturating at its maximum.
- R9: While `cfg_rx_en` is low, a start-of-frame is ignored and not counted. Clearing `cfg_rx_en` during a frame lets that frame complete and write its status.
- R10: While armed, bytes that arrive without a start-of-frame marker are ignored and produce no writes.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Byte address of the first descriptor |
| cfg_rx_en | input | 1 | Receive enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address for the read or write (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| missed_cnt | output | CNT_W | Saturating count of dropped frames |

## Verification
The frame lengths tried separate the byte-packing cases: a frame that is a whole number of words, one that ends in a partial word, a one-byte frame that starts and ends together, a frame exactly the buffer size, and a frame that overruns the buffer and must be truncated. Ownership is exercised three ways: the ring wraps onto a descriptor the host has not yet returned, a descriptor is handed back during polling, and a long burst of dropped frames drives the missed counter into saturation. Switching reception off while idle, and again in the middle of a frame, shows the difference between an ignored frame and one allowed to complete. Every memory write is matched in order against the reference model's expected address and data.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 25;
    localparam int ERR_BIT    = 15;
    localparam int LAST_BIT   = 8;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 14;
    localparam int DESC_BYTES = 16;
    localparam int CTL_OFS    = 4;
    localparam int BUF_OFS    = 8;

    typedef enum logic [3:0] {
        S_OFF,
        S_POLL_RD,
        S_POLL_WT,
        S_CTL_WT,
        S_BUF_WT,
        S_ARMED,
        S_FRAME,
        S_STAT,
        S_DONE
    } eng_state_t;
endpackage

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
    import rxd_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    input  logic             err_i,
    output logic [31:0]      word_o
);
    always_comb begin
        word_o                      = '0;
        word_o[LEN_LSB +: LEN_W]    = len_i;
        word_o[ERR_BIT]             = err_i;
        word_o[LAST_BIT]            = 1'b1;
        word_o[OWN_BIT]             = 1'b0;
    end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              wrap_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(DESC_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(DESC_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t q, d;
    logic [ADDR_W-1:0] base_al;

    always_comb begin
        base_al = base_i & ALIGN_MASK;
        d = q;
        if (load_i) begin
            d.ptr = base_al;
        end else if (adv_i) begin
            d.ptr = wrap_i ? base_al : q.ptr + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr_o = q.ptr;

    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ptr_o == $past(base_al)));
    p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wrap_i && !load_i) |=> (ptr_o == $past(base_al)));
    p_step_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wrap_i && !load_i) |=> (ptr_o == $past(ptr_o) + STEP));
endmodule

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_i,
    input  logic              vld_i,
    input  logic [7:0]        byte_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] buf_i,
    input  logic [LEN_W-1:0]  size_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] wa_o,
    output logic [31:0]       wd_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              trunc_o
);
    typedef struct packed {
        logic [LEN_W-1:0]  idx;
        logic [ADDR_W-1:0] bufa;
        logic [LEN_W-1:0]  size;
        logic [31:0]       acc;
        logic [ADDR_W-1:0] acc_addr;
        logic              pend;
        logic              trunc;
        logic              wr;
        logic [ADDR_W-1:0] wa;
        logic [31:0]       wd;
    } pk_st_t;

    pk_st_t q, d;

    logic [LEN_W-1:0]  idx_c;
    logic [ADDR_W-1:0] base_c;
    logic [LEN_W-1:0]  size_c;
    logic [31:0]       acc_c;
    logic              pend_c;
    logic              trunc_c;
    logic              store_c;
    logic [1:0]        lane_c;
    logic [31:0]       word_c;
    logic [ADDR_W-1:0] waddr_c;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        idx_c   = first_i ? '0     : q.idx;
        base_c  = first_i ? buf_i  : q.bufa;
        size_c  = first_i ? size_i : q.size;
        acc_c   = first_i ? '0     : q.acc;
        pend_c  = first_i ? 1'b0   : q.pend;
        trunc_c = first_i ? 1'b0   : q.trunc;
        store_c = idx_c < size_c;
        lane_c  = idx_c[1:0];
        word_c  = (lane_c == 2'd0) ? 32'd0 : acc_c;
        word_c[{lane_c, 3'b000} +: 8] = byte_i;
        waddr_c = base_c + ADDR_W'({idx_c[LEN_W-1:2], 2'b00});

        if (vld_i) begin
            d.bufa  = base_c;
            d.size  = size_c;
            d.trunc = trunc_c;
            d.pend  = pend_c;
            if (store_c) begin
                d.acc      = word_c;
                d.acc_addr = waddr_c;
                if (lane_c == 2'd3 || last_i) begin
                    d.wr   = 1'b1;
                    d.wa   = waddr_c;
                    d.wd   = word_c;
                    d.pend = 1'b0;
                end else begin
                    d.pend = 1'b1;
                end
            end else begin
                d.trunc = 1'b1;
                if (last_i && pend_c) begin
                    d.wr   = 1'b1;
                    d.wa   = q.acc_addr;
                    d.wd   = acc_c;
                    d.pend = 1'b0;
                end
            end
            d.idx = (&idx_c) ? idx_c : idx_c + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_o    = q.wr;
    assign wa_o    = q.wa;
    assign wd_o    = q.wd;
    assign len_o   = q.idx;
    assign trunc_o = q.trunc;

    p_in_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> ((wa_o - q.bufa) < ADDR_W'(q.size)));
    p_trunc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trunc_o && !first_i) |=> trunc_o);
    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (wa_o[1:0] == q.bufa[1:0]));
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_rx_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic [CNT_W-1:0]  missed_cnt
);
    localparam logic [ADDR_W-1:0] CTL_STEP = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] BUF_STEP = ADDR_W'(BUF_OFS);

    typedef struct packed {
        eng_state_t        st;
        logic [LEN_W-1:0]  size;
        logic              eor;
        logic [ADDR_W-1:0] bufa;
        logic [CNT_W-1:0]  missed;
        logic              swr;
        logic [ADDR_W-1:0] saddr;
        logic [31:0]       sdata;
    } top_st_t;

    top_st_t q, d;

    logic              rd_c;
    logic [ADDR_W-1:0] raddr_c;
    logic              pk_first;
    logic              pk_vld;
    logic              ptr_load;
    logic              ptr_adv;
    logic              not_armed;
    logic [ADDR_W-1:0] ptr;
    logic              pk_wr;
    logic [ADDR_W-1:0] pk_wa;
    logic [31:0]       pk_wd;
    logic [LEN_W-1:0]  pk_len;
    logic              pk_trunc;
    logic [31:0]       stat_word;
    logic              unused_rdata;

    assign unused_rdata = ^mem_rdata;

    rxd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load),
        .adv_i  (ptr_adv),
        .wrap_i (q.eor),
        .base_i (cfg_base),
        .ptr_o  (ptr)
    );

    rxd_byte_packer #(.ADDR_W(ADDR_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (pk_first),
        .vld_i   (pk_vld),
        .byte_i  (in_data),
        .last_i  (in_eof),
        .buf_i   (q.bufa),
        .size_i  (q.size),
        .wr_o    (pk_wr),
        .wa_o    (pk_wa),
        .wd_o    (pk_wd),
        .len_o   (pk_len),
        .trunc_o (pk_trunc)
    );

    rxd_status_fmt u_fmt (
        .len_i  (pk_len),
        .err_i  (pk_trunc),
        .word_o (stat_word)
    );

    always_comb begin
        d        = q;
        d.swr    = 1'b0;
        rd_c     = 1'b0;
        raddr_c  = ptr;
        pk_first = 1'b0;
        pk_vld   = 1'b0;
        ptr_load = 1'b0;
        ptr_adv  = 1'b0;

        not_armed = (q.st == S_POLL_RD) || (q.st == S_POLL_WT) ||
                    (q.st == S_CTL_WT)  || (q.st == S_BUF_WT)  ||
                    (q.st == S_STAT)    || (q.st == S_DONE);
        if (cfg_rx_en && in_valid && in_sof && not_armed && !(&q.missed)) begin
            d.missed = q.missed + 1'b1;
        end

        unique case (q.st)
            S_OFF: begin
                if (cfg_rx_en) begin
                    ptr_load = 1'b1;
                    d.st     = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                if (!cfg_rx_en) begin
                    d.st = S_OFF;
                end else begin
                    rd_c = 1'b1;
                    d.st = S_POLL_WT;
                end
            end
            S_POLL_WT: begin
                if (!cfg_rx_en) begin
                    d.st = S_OFF;
                end else if (mem_rdata[OWN_BIT]) begin
                    rd_c    = 1'b1;
                    raddr_c = ptr + CTL_STEP;
                    d.st    = S_CTL_WT;
                end else begin
                    d.st = S_POLL_RD;
                end
            end
            S_CTL_WT: begin
                if (!cfg_rx_en) begin
                    d.st = S_OFF;
                end else begin
                    d.size  = mem_rdata[LEN_W-1:0];
                    d.eor   = mem_rdata[WRAP_BIT];
                    rd_c    = 1'b1;
                    raddr_c = ptr + BUF_STEP;
                    d.st    = S_BUF_WT;
                end
            end
            S_BUF_WT: begin
                if (!cfg_rx_en) begin
                    d.st = S_OFF;
                end else begin
                    d.bufa = mem_rdata[ADDR_W-1:0];
                    d.st   = S_ARMED;
                end
            end
            S_ARMED: begin
                if (!cfg_rx_en) begin
                    d.st = S_OFF;
                end else if (in_valid && in_sof) begin
                    pk_first = 1'b1;
                    pk_vld   = 1'b1;
                    d.st     = in_eof ? S_STAT : S_FRAME;
                end
            end
            S_FRAME: begin
                if (in_valid) begin
                    pk_vld = 1'b1;
                    if (in_eof) d.st = S_STAT;
                end
            end
            S_STAT: begin
                d.swr   = 1'b1;
                d.saddr = ptr;
                d.sdata = stat_word;
                ptr_adv = 1'b1;
                d.st    = S_DONE;
            end
            S_DONE: begin
                d.st = cfg_rx_en ? S_POLL_RD : S_OFF;
            end
            default: d.st = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd     = rd_c;
    assign mem_wr     = pk_wr | q.swr;
    assign mem_addr   = pk_wr ? pk_wa : (q.swr ? q.saddr : raddr_c);
    assign mem_wdata  = pk_wr ? pk_wd : q.sdata;
    assign missed_cnt = q.missed;

    p_single_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + 1'b1));
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_OFF) |-> (!mem_rd && !mem_wr));
    p_status_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.swr |-> (mem_wr && !mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT]));
    p_no_data_after_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.swr |-> !pk_wr);
endmodule

// File: tb/tb_rxd_ring_writer.sv
module tb_rxd_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int CNT_W      = 8;
    localparam int WD_CYCLES  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic              cfg_rx_en = 1'b0;
    logic              mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic [CNT_W-1:0]  missed_cnt;

    logic [31:0] ram [0:255];

    int    compared = 0;
    int    mismatched = 0;
    bit    running = 0;
    bit    quiet = 0;
    string cur_req = "R1";
    int    exp_missed = 0;
    logic [15:0] model_base = '0;
    logic [15:0] model_ptr = '0;
    logic [15:0] qa[$];
    logic [31:0] qd[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ring_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_rx_en(cfg_rx_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .missed_cnt(missed_cnt)
    );

    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr[9:2]] = mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr[9:2]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            chk("R8", "missed_cnt", 32'(missed_cnt), 32'(exp_missed));
            chk("R11", "rd and wr together", 32'(mem_rd && mem_wr), 32'd0);
            if (quiet) chk("R9", "port active while off", 32'(mem_rd || mem_wr), 32'd0);
            if (mem_wr) begin
                if (qa.size() == 0) begin
                    chk(cur_req, "unexpected write addr", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    chk(cur_req, "write addr", 32'(mem_addr), 32'(qa.pop_front()));
                    chk(cur_req, "write data", mem_wdata, qd.pop_front());
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed + 7 * k);
    endfunction

    function automatic logic [31:0] stat_word(input int n, input bit err);
        logic [31:0] w;
        w = '0;
        w[29:16] = 14'(n);
        w[15] = err;
        w[8] = 1'b1;
        return w;
    endfunction

    // Behavioural model of one accepted frame at the model pointer.
    task automatic expect_frame(input int n, input int seed);
        int p, stored, size, bufa;
        bit eor;
        logic [31:0] word;
        p      = int'(model_ptr);
        size   = int'(ram[p/4 + 1][13:0]);
        eor    = ram[p/4 + 1][25];
        bufa   = int'(ram[p/4 + 2][15:0]);
        stored = (n < size) ? n : size;
        for (int k = 0; k < stored; k += 4) begin
            word = '0;
            for (int j = 0; j < 4; j++)
                if (k + j < stored) word[8*j +: 8] = pat(seed, k + j);
            qa.push_back(16'(bufa + k));
            qd.push_back(word);
        end
        qa.push_back(16'(p));
        qd.push_back(stat_word(n, n > size));
        model_ptr = eor ? model_base : 16'(p + 16);
    endtask

    task automatic send(input int n, input int seed, input bit with_sof,
                        input bit dropped, input int off_at);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_sof   = with_sof && (k == 0);
            in_eof   = (k == n - 1);
            in_data  = pat(seed, k);
            if (k == off_at) cfg_rx_en = 1'b0;
            step();
            if (k == 0 && dropped) exp_missed = (exp_missed == 255) ? 255 : exp_missed + 1;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic enable(input logic [15:0] b);
        cfg_base   = b;
        cfg_rx_en  = 1'b1;
        model_base = b & 16'hFFF0;
        model_ptr  = model_base;
    endtask

    task automatic set_desc(input int a, input bit own, input int size,
                            input bit wrap, input int bufa);
        ram[a/4]     = own ? 32'h8000_0000 : 32'h0;
        ram[a/4 + 1] = (wrap ? 32'h0200_0000 : 32'h0) | 32'(size);
        ram[a/4 + 2] = 32'(bufa);
        ram[a/4 + 3] = 32'h0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 32'h0;
        idle(4);
        #1;
        chk("R1", "mem_rd in reset", 32'(mem_rd), 32'd0);
        chk("R1", "mem_wr in reset", 32'(mem_wr), 32'd0);
        chk("R1", "missed in reset", 32'(missed_cnt), 32'd0);
        rst_n = 1'b1;
        step();
        running = 1;
        quiet = 1;
        cur_req = "R1";
        idle(6);
        quiet = 0;

        set_desc(32'h100, 1, 16, 0, 32'h200);
        set_desc(32'h110, 1, 6,  0, 32'h240);
        set_desc(32'h120, 1, 6,  1, 32'h280);

        // R2: base low bits ignored, ring entered at 0x100
        cur_req = "R2";
        enable(16'h010C);
        idle(12);

        // R4/R5: whole-word frame
        cur_req = "R4";
        expect_frame(8, 3);
        send(8, 3, 1, 0, -1);
        idle(12);
        chk("R5", "status d0", ram[32'h100/4], stat_word(8, 0));

        // R6: exact-size frame, no error
        cur_req = "R6";
        expect_frame(6, 40);
        send(6, 40, 1, 0, -1);
        idle(12);
        chk("R6", "status exact", ram[32'h110/4], stat_word(6, 0));

        // R6/R7: truncated frame on wrap descriptor
        cur_req = "R7";
        expect_frame(10, 90);
        send(10, 90, 1, 0, -1);
        idle(12);
        chk("R6", "status truncated", ram[32'h120/4], stat_word(10, 1));
        chk("R6", "no write past buffer", ram[32'h288/4], 32'h0);

        // R8: wrapped onto host-owned d0, frame dropped
        cur_req = "R8";
        send(3, 5, 1, 1, -1);
        idle(12);
        chk("R8", "d0 untouched", ram[32'h100/4], stat_word(8, 0));

        // R3: hand back d0 and d1 while polling
        set_desc(32'h100, 1, 16, 0, 32'h200);
        set_desc(32'h110, 1, 6,  0, 32'h240);
        idle(12);

        // R10: stray bytes while armed
        cur_req = "R10";
        send(3, 60, 0, 0, -1);
        idle(6);

        // R3/R4: partial final word
        cur_req = "R3";
        expect_frame(5, 17);
        send(5, 17, 1, 0, -1);
        idle(12);
        chk("R4", "partial word lanes", ram[32'h204/4], {24'h0, pat(17, 4)});

        // R4: single-byte frame
        cur_req = "R4";
        expect_frame(1, 200);
        send(1, 200, 1, 0, -1);
        idle(12);
        chk("R5", "status one byte", ram[32'h110/4], stat_word(1, 0));

        // R9: disabled, frame ignored and not counted
        cur_req = "R9";
        cfg_rx_en = 1'b0;
        step();
        quiet = 1;
        idle(4);
        send(4, 9, 1, 0, -1);
        idle(6);
        quiet = 0;

        // R2: new base, single wrapping descriptor
        cur_req = "R2";
        set_desc(32'h140, 1, 16, 1, 32'h2C0);
        enable(16'h0140);
        idle(12);
        expect_frame(4, 70);
        send(4, 70, 1, 0, -1);
        idle(12);
        chk("R7", "status wrap ring", ram[32'h140/4], stat_word(4, 0));

        // R9: disable in the middle of a frame, it still completes
        cur_req = "R9";
        set_desc(32'h140, 1, 16, 1, 32'h2C0);
        idle(12);
        expect_frame(8, 120);
        send(8, 120, 1, 0, 2);
        idle(12);
        chk("R9", "status after mid-frame off", ram[32'h140/4], stat_word(8, 0));

        // R8: saturating missed counter on host-owned descriptor
        cur_req = "R8";
        enable(16'h0140);
        idle(12);
        for (int i = 0; i < 300; i++) begin
            send(1, i, 1, 1, -1);
            step();
        end
        idle(4);
        chk("R8", "missed saturated", 32'(missed_cnt), 32'd255);
        chk("R5", "all expected writes seen", 32'(qa.size()), 32'd0);

        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired (R1) actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule